// File: doc/BRIEF.md
# PCIe Root Port Bring-up Sequencer

This block brings a PCIe root port from power-on to a trained link with no processor involvement. After a start pulse it turns on the port clock. When requested, it pulses the PHY management reset and loads a fixed list of PHY settings through a serial management command word. It then pulses the PHY reset with link training enabled and holds the attached device in reset for a while before releasing it. It issues a second PHY reset and, after a settle time, polls the link-training state until the link reports up or the poll budget runs out.

Every wait is a whole number of ticks. A tick is `PRESCALE` clock cycles, so the default of 125000 gives one millisecond at 125 MHz. All tick counts are parameters, which lets a simulation shrink the timeline. The block does not drive the PHY or the device directly. It presents one-cycle write strobes with data for the control registers that sit next to it. It also presents two levels: the port clock enable and the active-low device reset.

Top module: `pcie_bringup_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, the block is idle. `busy`, `done`, `link_up` and `timeout` are low, `port_clk_en` is low and `perst_n` is high. All three write strobes are low.
- R2: A `start` pulse accepted in the idle or done state begins the sequence with one action cycle. After that cycle `port_clk_en` is 1, and a wait of `T_CLK` ticks follows. A wait of N ticks lasts exactly N*`PRESCALE` cycles.
- R3: If `table_en` was high when `start` was accepted, three management-reset writes come next, on consecutive cycles. Their `mgmt_data` values are 0x8, then 0x9, then 0xB.
- R4: A PHY reset is two writes on consecutive cycles: `phy_data` 0x01 (reset held, training enabled), then 0x81 (reset released, training enabled). The first pair comes after the clock wait or the management writes and is followed by `T_PHY` ticks.
- R5: A management command word carries the data in bits [31:16] and the 5-bit register address in bits [12:8]. Bit 0 is 1 to mark a write, and all other bits are 0.
- R6: When `table_en` was high at start, eleven command words follow the first PHY reset, one write each followed by `T_MDIO` ticks. In order, the (address, data) pairs are (0x00,0x5027), (0x02,0x6D18), (0x06,0x8828), (0x07,0x30FF), (0x08,0x18D7), (0x0A,0x00E9), (0x0B,0x0511), (0x0D,0x15B6), (0x0F,0x0F0F), (0x05,0x0BCB), (0x06,0x8128). When `table_en` was low, both the management writes and the table are skipped.
- R7: After that, `perst_n` goes low for `T_PERST` ticks and then returns high. The second PHY reset pair follows on the next cycles, then a settle wait of `T_SETTLE` ticks.
- R8: Polling samples `link_state` once per poll cycle. The link counts as up when `link_state[4:0]` equals 0x11, and bits above bit 4 are ignored. Failed polls are spaced by `T_POLL` ticks. On success the block enters done with `link_up` high.
- R9: If `POLL_MAX` polls in a row fail, the block enters done with `timeout` high and `link_up` low.
- R10: `busy` is high from the first action cycle until done is reached. A `start` pulse while `busy` is high has no effect on any output.
- R11: `done`, `link_up` and `timeout` hold their values until the next accepted start. The next accepted start clears all three in the following cycle.
- R12: `mgmt_data`, `phy_data` and `mdio_cmd` are zero in every cycle in which their strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts the sequence when idle or done |
| table_en | input | 1 | Selects the management reset and table load, sampled at start |
| link_state | input | LINK_W | Link-training state; low 5 bits compared |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |
| link_up | output | 1 | Finished with link trained |
| timeout | output | 1 | Finished with poll budget exhausted |
| port_clk_en | output | 1 | Port clock enable level |
| perst_n | output | 1 | Device reset, active low |
| mgmt_we | output | 1 | Management-reset register write strobe |
| mgmt_data | output | 4 | Management-reset register value |
| phy_we | output | 1 | PHY control register write strobe |
| phy_data | output | 8 | PHY control register value |
| mdio_we | output | 1 | Management command register write strobe |
| mdio_cmd | output | 32 | Management command word |

## Verification
The hardest case to reach is a link that comes up part-way through the poll window. That tests both the poll spacing and the point at which polling stops, and it depends on the exact cycle of each poll relative to a `link_state` change. The bench drives `link_state` from its own cycle counter against a chosen change-over cycle. Its reference model evaluates the same function at each poll cycle it predicts, so an early, late or missed poll shows up as a different outcome or a different done cycle. Separate runs cover these cases:
- a link already up at the first poll;
- a link that never comes up, with the upper bits of `link_state` set so that only the low-five-bit comparison decides;
- a restart from done, with a start pulse issued mid-run.

// File: rtl/pbs_pkg.sv
`timescale 1ns/1ps
// pbs_pkg: shared state encoding, register codes and helpers for the
// PCIe bring-up sequencer. Assumes no tool-specific features.
package pbs_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_CLK_ON, S_MRST_A, S_MRST_B, S_MRST_C,
        S_PHY1_A, S_PHY1_B, S_TBL, S_PERST_LO, S_PERST_HI,
        S_PHY2_A, S_PHY2_B, S_POLL, S_WAIT, S_DONE
    } seq_state_t;

    localparam int          TBL_LEN      = 11;
    localparam logic [4:0]  LINK_UP_CODE = 5'h11;
    localparam logic [3:0]  MGMT_HOLD    = 4'h8;
    localparam logic [3:0]  MGMT_RUN     = 4'h9;
    localparam logic [3:0]  MGMT_LOADED  = 4'hB;
    localparam logic [7:0]  PHY_HOLD     = 8'h01;
    localparam logic [7:0]  PHY_RUN      = 8'h81;

    // Larger of two integers, used to size counters.
    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Packs a management write command word.
    function automatic logic [31:0] make_cmd(input logic [4:0] addr, input logic [15:0] data);
        return {data, 3'b000, addr, 7'b0000000, 1'b1};
    endfunction

endpackage

// File: rtl/pbs_tick_timer.sv
`timescale 1ns/1ps
// pbs_tick_timer: prescaled down-counter. A load of N ticks makes expire
// rise in the N*PRESCALE-th cycle after the load cycle. Assumes N >= 1.
module pbs_tick_timer #(
    parameter int PRESCALE = 125000,
    parameter int CNT_W    = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] ticks,
    output logic             expire
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] left;

    // Counts cycles within a tick and ticks within the wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre  <= '0;
            left <= '0;
        end else if (load) begin
            pre  <= PRE_TOP;
            left <= ticks;
        end else if (left != '0) begin
            if (pre == '0) begin
                pre  <= PRE_TOP;
                left <= left - 1'b1;
            end else begin
                pre <= pre - 1'b1;
            end
        end
    end

    // Last cycle of the last tick.
    assign expire = (left == CNT_W'(1)) && (pre == '0);

    // R2: a wait longer than one tick never ends in the cycle after its load.
    a_r2_no_early_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ticks > CNT_W'(1)) |=> !expire);

endmodule

// File: rtl/pbs_phy_table.sv
`timescale 1ns/1ps
// pbs_phy_table: fixed list of PHY settings, returned as ready command
// words. Indices beyond the list return a zero word.
module pbs_phy_table #(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx,
    output logic [31:0]      cmd
);
    import pbs_pkg::*;

    // Maps an index to its (address, data) command word.
    always_comb begin
        case (idx)
            IDX_W'(0):  cmd = make_cmd(5'h00, 16'h5027);
            IDX_W'(1):  cmd = make_cmd(5'h02, 16'h6D18);
            IDX_W'(2):  cmd = make_cmd(5'h06, 16'h8828);
            IDX_W'(3):  cmd = make_cmd(5'h07, 16'h30FF);
            IDX_W'(4):  cmd = make_cmd(5'h08, 16'h18D7);
            IDX_W'(5):  cmd = make_cmd(5'h0A, 16'h00E9);
            IDX_W'(6):  cmd = make_cmd(5'h0B, 16'h0511);
            IDX_W'(7):  cmd = make_cmd(5'h0D, 16'h15B6);
            IDX_W'(8):  cmd = make_cmd(5'h0F, 16'h0F0F);
            IDX_W'(9):  cmd = make_cmd(5'h05, 16'h0BCB);
            IDX_W'(10): cmd = make_cmd(5'h06, 16'h8128);
            default:    cmd = '0;
        endcase
    end

endmodule

// File: rtl/pcie_bringup_seq.sv
`timescale 1ns/1ps
// pcie_bringup_seq: autonomous root-port power-up sequence. It enables the
// clock, optionally resets the management block and loads the PHY table,
// resets the PHY, pulses the device reset, resets the PHY again and polls
// the link. Assumes every tick count parameter is at least 1.
module pcie_bringup_seq #(
    parameter int PRESCALE   = 125000,
    parameter int T_CLK      = 100,
    parameter int T_MDIO     = 1,
    parameter int T_PHY      = 100,
    parameter int T_PERST    = 300,
    parameter int T_SETTLE   = 1100,
    parameter int T_POLL     = 100,
    parameter int POLL_MAX   = 99,
    parameter int LINK_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              table_en,
    input  logic [LINK_W-1:0] link_state,
    output logic              busy,
    output logic              done,
    output logic              link_up,
    output logic              timeout,
    output logic              port_clk_en,
    output logic              perst_n,
    output logic              mgmt_we,
    output logic [3:0]        mgmt_data,
    output logic              phy_we,
    output logic [7:0]        phy_data,
    output logic              mdio_we,
    output logic [31:0]       mdio_cmd
);
    import pbs_pkg::*;

    localparam int T_MAX = max_of(max_of(max_of(T_CLK, T_MDIO), max_of(T_PHY, T_PERST)),
                                  max_of(T_SETTLE, T_POLL));
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam int PW    = $clog2(POLL_MAX + 1);
    localparam int IDX_W = $clog2(TBL_LEN + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TBL_LEN - 1);
    localparam logic [PW-1:0]    POLL_LAST = PW'(POLL_MAX - 1);

    seq_state_t       state, nxt, ret_state, ret_nxt;
    logic [IDX_W-1:0] tbl_idx;
    logic [PW-1:0]    poll_cnt;
    logic             run_tbl;
    logic             tmr_load, tmr_expire;
    logic [CNT_W-1:0] tmr_ticks;
    logic [31:0]      tbl_cmd;
    logic             link_seen;

    assign link_seen = (link_state[4:0] == LINK_UP_CODE);

    pbs_tick_timer #(.PRESCALE(PRESCALE), .CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .ticks  (tmr_ticks),
        .expire (tmr_expire)
    );

    pbs_phy_table #(.IDX_W(IDX_W)) u_table (
        .idx (tbl_idx),
        .cmd (tbl_cmd)
    );

    // Next state, return state and wait length for each step.
    always_comb begin
        nxt       = state;
        ret_nxt   = ret_state;
        tmr_load  = 1'b0;
        tmr_ticks = '0;
        case (state)
            S_IDLE, S_DONE: if (start) nxt = S_CLK_ON;
            S_CLK_ON: begin
                tmr_load = 1'b1; tmr_ticks = CNT_W'(T_CLK);
                nxt = S_WAIT; ret_nxt = run_tbl ? S_MRST_A : S_PHY1_A;
            end
            S_MRST_A: nxt = S_MRST_B;
            S_MRST_B: nxt = S_MRST_C;
            S_MRST_C: nxt = S_PHY1_A;
            S_PHY1_A: nxt = S_PHY1_B;
            S_PHY1_B: begin
                tmr_load = 1'b1; tmr_ticks = CNT_W'(T_PHY);
                nxt = S_WAIT; ret_nxt = run_tbl ? S_TBL : S_PERST_LO;
            end
            S_TBL: begin
                tmr_load = 1'b1; tmr_ticks = CNT_W'(T_MDIO);
                nxt = S_WAIT; ret_nxt = (tbl_idx == IDX_LAST) ? S_PERST_LO : S_TBL;
            end
            S_PERST_LO: begin
                tmr_load = 1'b1; tmr_ticks = CNT_W'(T_PERST);
                nxt = S_WAIT; ret_nxt = S_PERST_HI;
            end
            S_PERST_HI: nxt = S_PHY2_A;
            S_PHY2_A:   nxt = S_PHY2_B;
            S_PHY2_B: begin
                tmr_load = 1'b1; tmr_ticks = CNT_W'(T_SETTLE);
                nxt = S_WAIT; ret_nxt = S_POLL;
            end
            S_POLL: begin
                if (link_seen || poll_cnt == POLL_LAST) begin
                    nxt = S_DONE;
                end else begin
                    tmr_load = 1'b1; tmr_ticks = CNT_W'(T_POLL);
                    nxt = S_WAIT; ret_nxt = S_POLL;
                end
            end
            S_WAIT: if (tmr_expire) nxt = ret_state;
            default: nxt = S_IDLE;
        endcase
    end

    // State registers, levels, counters and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            ret_state   <= S_IDLE;
            tbl_idx     <= '0;
            poll_cnt    <= '0;
            run_tbl     <= 1'b0;
            port_clk_en <= 1'b0;
            perst_n     <= 1'b1;
            link_up     <= 1'b0;
            timeout     <= 1'b0;
        end else begin
            state     <= nxt;
            ret_state <= ret_nxt;
            case (state)
                S_IDLE, S_DONE: if (start) begin
                    run_tbl  <= table_en;
                    link_up  <= 1'b0;
                    timeout  <= 1'b0;
                    poll_cnt <= '0;
                    tbl_idx  <= '0;
                end
                S_CLK_ON:   port_clk_en <= 1'b1;
                S_TBL:      tbl_idx <= tbl_idx + 1'b1;
                S_PERST_LO: perst_n <= 1'b0;
                S_PERST_HI: perst_n <= 1'b1;
                S_POLL: begin
                    if (link_seen)                  link_up  <= 1'b1;
                    else if (poll_cnt == POLL_LAST) timeout  <= 1'b1;
                    else                            poll_cnt <= poll_cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Status and register strobes decoded from the current step.
    always_comb begin
        busy      = (state != S_IDLE) && (state != S_DONE);
        done      = (state == S_DONE);
        mgmt_we   = (state == S_MRST_A) || (state == S_MRST_B) || (state == S_MRST_C);
        mgmt_data = (state == S_MRST_A) ? MGMT_HOLD :
                    (state == S_MRST_B) ? MGMT_RUN  :
                    (state == S_MRST_C) ? MGMT_LOADED : 4'h0;
        phy_we    = (state == S_PHY1_A) || (state == S_PHY1_B) ||
                    (state == S_PHY2_A) || (state == S_PHY2_B);
        phy_data  = ((state == S_PHY1_A) || (state == S_PHY2_A)) ? PHY_HOLD :
                    ((state == S_PHY1_B) || (state == S_PHY2_B)) ? PHY_RUN  : 8'h00;
        mdio_we   = (state == S_TBL);
        mdio_cmd  = (state == S_TBL) ? tbl_cmd : 32'h0;
    end

    // R2: the device is never put into reset while the port clock is off.
    a_r2_clock_before_perst: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(perst_n) |-> port_clk_en);
    // R3: the load-done write directly follows another management write.
    a_r3_mgmt_order: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_we && mgmt_data == MGMT_LOADED) |-> $past(mgmt_we && mgmt_data == MGMT_RUN));
    // R4: a PHY release write always follows a PHY hold write.
    a_r4_phy_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_we && phy_data == PHY_RUN) |-> $past(phy_we && phy_data == PHY_HOLD));
    // R6: table writes are separated by a wait.
    a_r6_mdio_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_we |=> !mdio_we);
    // R5: a command word marks a write and keeps its reserved bits clear.
    a_r5_cmd_format: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_we |-> (mdio_cmd[0] && mdio_cmd[15:13] == 3'b000 && mdio_cmd[7:1] == 7'd0));
    // R9: the two outcomes never coexist.
    a_r9_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_up && timeout));
    // R10: start during a run never restarts it.
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> state != S_CLK_ON);
    // R11: done holds until a start arrives.
    a_r11_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(link_up) && $stable(timeout)));

endmodule

// File: tb/pcie_bringup_seq_test.sv
`timescale 1ns/1ps
// Bench for pcie_bringup_seq: a behavioural model builds the expected
// per-cycle output list for each run and is compared on every cycle.
module pcie_bringup_seq_test;

    localparam int PS = 3, TC = 4, TM = 1, TP = 2, TPE = 5, TS = 3, TQ = 2, PM = 4;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, table_en = 1'b0;
    logic [7:0]  link_state = 8'h00;
    logic        busy, done, link_up, timeout, port_clk_en, perst_n;
    logic        mgmt_we, phy_we, mdio_we;
    logic [3:0]  mgmt_data;
    logic [7:0]  phy_data;
    logic [31:0] mdio_cmd;

    pcie_bringup_seq #(.PRESCALE(PS), .T_CLK(TC), .T_MDIO(TM), .T_PHY(TP), .T_PERST(TPE),
                       .T_SETTLE(TS), .T_POLL(TQ), .POLL_MAX(PM), .LINK_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .table_en(table_en), .link_state(link_state),
        .busy(busy), .done(done), .link_up(link_up), .timeout(timeout),
        .port_clk_en(port_clk_en), .perst_n(perst_n), .mgmt_we(mgmt_we), .mgmt_data(mgmt_data),
        .phy_we(phy_we), .phy_data(phy_data), .mdio_we(mdio_we), .mdio_cmd(mdio_cmd));

    always #4 clk = ~clk;

    typedef struct packed {
        logic busy, done, lup, tmo, cen, prst, mwe;
        logic [3:0] md;
        logic pwe;
        logic [7:0] pd;
        logic cwe;
        logic [31:0] cw;
    } snap_t;

    snap_t  exp_q[$];
    snap_t  cur_exp;
    int     tests = 0, fails = 0;
    longint cyc = 0, gc = 0;
    bit     m_cen = 1'b0, m_prst = 1'b1;
    longint up_at = 64'h7fffffff;
    logic [7:0] up_val = 8'h11, dn_val = 8'h00;

    logic [4:0]  ta [11] = '{5'h00, 5'h02, 5'h06, 5'h07, 5'h08, 5'h0A, 5'h0B, 5'h0D, 5'h0F, 5'h05, 5'h06};
    logic [15:0] td [11] = '{16'h5027, 16'h6D18, 16'h8828, 16'h30FF, 16'h18D7, 16'h00E9,
                             16'h0511, 16'h15B6, 16'h0F0F, 16'h0BCB, 16'h8128};

    function automatic logic [7:0] ls_at(input longint c);
        return (c >= up_at) ? up_val : dn_val;
    endfunction

    function automatic snap_t plain(input bit b);
        snap_t s = '0;
        s.busy = b; s.cen = m_cen; s.prst = m_prst;
        return s;
    endfunction

    task automatic push(input snap_t s);
        exp_q.push_back(s);
        gc++;
    endtask

    task automatic hold(input int t);
        repeat (t * PS) push(plain(1'b1));
    endtask

    task automatic phy_pair();
        snap_t s;
        s = plain(1'b1); s.pwe = 1'b1; s.pd = 8'h01; push(s);
        s = plain(1'b1); s.pwe = 1'b1; s.pd = 8'h81; push(s);
    endtask

    // Expected outputs of one whole run, starting at snapshot 'base'.
    task automatic gen_run(input bit tbl, input longint base);
        snap_t s;
        int k;
        bit ok;
        gc = base;
        push(plain(1'b1)); m_cen = 1'b1; hold(TC);
        if (tbl) begin
            s = plain(1'b1); s.mwe = 1'b1; s.md = 4'h8; push(s);
            s.md = 4'h9; push(s);
            s.md = 4'hB; push(s);
        end
        phy_pair(); hold(TP);
        if (tbl) begin
            for (int i = 0; i < 11; i++) begin
                s = plain(1'b1); s.cwe = 1'b1; s.cw = {td[i], 3'b000, ta[i], 7'd0, 1'b1};
                push(s); hold(TM);
            end
        end
        push(plain(1'b1)); m_prst = 1'b0; hold(TPE);
        push(plain(1'b1)); m_prst = 1'b1;
        phy_pair(); hold(TS);
        k = 0; ok = 1'b0;
        forever begin
            longint c_now = gc;
            push(plain(1'b1));
            k++;
            if (ls_at(c_now) [4:0] == 5'h11) begin ok = 1'b1; break; end
            if (k == PM) break;
            hold(TQ);
        end
        s = plain(1'b0); s.done = 1'b1; s.lup = ok; s.tmo = !ok; push(s);
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] ev);
        tests++;
        if (act !== ev) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, ev, cyc);
        end
    endtask

    task automatic cmp_all(input snap_t e);
        chk("R10", "busy", 32'(busy), 32'(e.busy));
        chk("R11", "done", 32'(done), 32'(e.done));
        chk("R8", "link_up", 32'(link_up), 32'(e.lup));
        chk("R9", "timeout", 32'(timeout), 32'(e.tmo));
        chk("R2", "port_clk_en", 32'(port_clk_en), 32'(e.cen));
        chk("R7", "perst_n", 32'(perst_n), 32'(e.prst));
        chk("R3", "mgmt_we", 32'(mgmt_we), 32'(e.mwe));
        chk(e.mwe ? "R3" : "R12", "mgmt_data", 32'(mgmt_data), 32'(e.md));
        chk("R4", "phy_we", 32'(phy_we), 32'(e.pwe));
        chk(e.pwe ? "R4" : "R12", "phy_data", 32'(phy_data), 32'(e.pd));
        chk("R6", "mdio_we", 32'(mdio_we), 32'(e.cwe));
        chk(e.cwe ? "R5 R6" : "R12", "mdio_cmd", mdio_cmd, e.cw);
    endtask

    // One cycle: compare, then drive inputs for the coming edge.
    task automatic step(input bit st, input bit tbl);
        @(negedge clk);
        cyc++;
        if (exp_q.size() > 0) cur_exp = exp_q.pop_front();
        cmp_all(cur_exp);
        link_state = ls_at(cyc);
        start = st;
        table_en = tbl;
        if (st && !cur_exp.busy) gen_run(tbl, cyc + 1);
    endtask

    task automatic run_done(input bit tbl);
        int n = 0;
        while ((exp_q.size() > 0 || cur_exp.busy) && n < 5000) begin
            step(1'b0, tbl);
            n++;
        end
        if (n >= 5000) begin
            fails++;
            $display("FAIL R10 watchdog: actual busy expected idle");
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        cur_exp = plain(1'b0);
        repeat (3) @(negedge clk);
        // R1: state while reset is applied
        cmp_all(cur_exp);
        rst_n = 1'b1;
        repeat (3) step(1'b0, 1'b0);

        // Run A: table load, link comes up part-way through polling, upper bits set (R8)
        up_at = cyc + 106; up_val = 8'hF1; dn_val = 8'h10;
        step(1'b1, 1'b1);
        run_done(1'b1);
        repeat (10) step(1'b0, 1'b0);
        chk("R8", "link_up after run A", 32'(link_up), 32'd1);
        chk("R11", "done held after run A", 32'(done), 32'd1);

        // Run B: restart from done, no table, link never up, mid-run start ignored (R9, R10)
        up_at = 64'h7fffffff; dn_val = 8'hE1;
        step(1'b1, 1'b0);
        repeat (15) step(1'b0, 1'b0);
        step(1'b1, 1'b1);
        run_done(1'b0);
        repeat (6) step(1'b0, 1'b0);
        chk("R9", "timeout after run B", 32'(timeout), 32'd1);
        chk("R9", "link_up after run B", 32'(link_up), 32'd0);

        // Run C: link already up at the first poll
        up_at = 0; up_val = 8'h11;
        step(1'b1, 1'b1);
        run_done(1'b1);
        repeat (4) step(1'b0, 1'b0);
        chk("R8", "link_up after run C", 32'(link_up), 32'd1);
        chk("R11", "timeout cleared by restart", 32'(timeout), 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule